// File: doc/BRIEF.md
# Lane-Partitioned SIMD Integer Adder

This block adds two 128-bit vector operands lane by lane in one clock. A three-bit mode code picks how the 128 bits are cut into lanes: sixteen bytes, eight halfwords, four words or two doublewords. All lane arrangements share one chain of byte-sized adder segments. The mode code decides at which byte boundaries the carry between segments is cut, so no carry crosses from one lane into the next.

The same chain also has a narrowing mode and a widening mode. In narrowing mode, four 32-bit sums are reduced to their low halves and packed into the lower 64 bits of the result. In widening mode, the four lowest 16-bit elements of each operand are sign-extended to 32 bits before they are added.

The result and its valid flag are registered. They appear one clock after the valid input strobe.

Top module: `simd_lane_adder`

## Requirements
- R1: A synchronous active-high reset clears both the result and the valid flag to zero.
- R2: When the valid input is high at a rising clock edge, the valid output goes high after that edge and the result register loads the new sum. Otherwise the valid output is low after the edge.
- R3: When the valid input is low at an edge, the result register keeps its value, even if the operands or the mode change.
- R4: Mode code 0 gives sixteen 8-bit lanes. Each lane sum wraps modulo 2^8, and no carry passes to the next lane.
- R5: Mode code 1 gives eight 16-bit lanes. Each lane sum wraps modulo 2^16.
- R6: Mode code 2 gives four 32-bit lanes. Each lane sum wraps modulo 2^32.
- R7: Mode code 3 gives two 64-bit lanes. Each lane sum wraps modulo 2^64.
- R8: Element i of a lane width W occupies bits [i*W+W-1 : i*W]. Each result lane depends only on the same-numbered lanes of the two operands.
- R9: Mode code 4 (narrow) adds four 32-bit lanes. It places the low 16 bits of sum k at bits [16k+15:16k] and forces bits 127:64 to zero.
- R10: Mode code 5 (widen) sign-extends the 16-bit elements at bits 63:0 of each operand to 32 bits. It places the four 32-bit sums in lanes of 32 bits.
- R11: Mode codes 6 and 7 are reserved. With a valid input, they load an all-zero result and raise the valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operands and mode are valid this cycle |
| inMode | input | 3 | Lane arrangement or mode code (0 to 7) |
| inOpA | input | 128 | First vector operand |
| inOpB | input | 128 | Second vector operand |
| outValid | output | 1 | Result register holds a fresh sum |
| outResult | output | 128 | Registered lane-wise sum |

## Verification

The bench drives all-ones plus one in every lane arrangement. A design that leaked a carry across a lane cut would show a 1 at the bottom of the next lane instead of zeros everywhere. Narrowing is tested with sums above 16 bits, to catch a design that saturates or fails to clear the upper half. Widening is tested with negative halfwords, to catch zero extension in place of sign extension and bits read from the wrong half of the operands. Random operands in every mode, reserved codes, and idle cycles with changing operands cover the remaining cases: wrong lane placement, reserved codes that leak sums, and a result register that fails to hold.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

  parameter int VEC_W  = 128;
  parameter int SEG_W  = 8;
  localparam int NUM_SEG = VEC_W / SEG_W;
  localparam int NUM_CUT = NUM_SEG - 1;
  localparam int MODE_W  = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_B8     = 3'd0,
    MODE_H16    = 3'd1,
    MODE_W32    = 3'd2,
    MODE_D64    = 3'd3,
    MODE_NARROW = 3'd4,
    MODE_WIDEN  = 3'd5,
    MODE_RSV6   = 3'd6,
    MODE_RSV7   = 3'd7
  } addMode_t;

  typedef struct packed {
    logic               load;
    logic               widen;
    logic               narrow;
    logic               blank;
    logic [NUM_CUT-1:0] cut;
  } ctrlStrobes_t;

endpackage

// File: rtl/simd_add_ctrl.sv
module simd_add_ctrl
  import simd_add_pkg::*;
(
  input  logic              inValid,
  input  logic [MODE_W-1:0] inMode,
  output ctrlStrobes_t      strobes
);

  logic [NUM_CUT-1:0] cut8;
  logic [NUM_CUT-1:0] cut16;
  logic [NUM_CUT-1:0] cut32;
  logic [NUM_CUT-1:0] cut64;

  // One mask per lane width: bit i is set when the byte boundary above
  // segment i is also a lane boundary.
  for (genvar i = 0; i < NUM_CUT; i++) begin : g_cutMask
    localparam logic At16 = ((i + 1) % 2) == 0;
    localparam logic At32 = ((i + 1) % 4) == 0;
    localparam logic At64 = ((i + 1) % 8) == 0;
    assign cut8[i]  = 1'b1;
    assign cut16[i] = At16;
    assign cut32[i] = At32;
    assign cut64[i] = At64;
  end

  always_comb begin
    strobes        = '0;
    strobes.load   = inValid;
    unique case (addMode_t'(inMode))
      MODE_B8:     strobes.cut = cut8;
      MODE_H16:    strobes.cut = cut16;
      MODE_W32:    strobes.cut = cut32;
      MODE_D64:    strobes.cut = cut64;
      MODE_NARROW: begin
        strobes.cut    = cut32;
        strobes.narrow = 1'b1;
      end
      MODE_WIDEN: begin
        strobes.cut   = cut32;
        strobes.widen = 1'b1;
      end
      default: begin
        strobes.cut   = cut8;
        strobes.blank = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/simd_add_datapath.sv
module simd_add_datapath
  import simd_add_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strobes,
  input  logic [VEC_W-1:0] opA,
  input  logic [VEC_W-1:0] opB,
  output logic             resValid,
  output logic [VEC_W-1:0] resData
);

  localparam int WORD_W  = 32;
  localparam int HALF_W  = 16;
  localparam int NUM_WRD = VEC_W / WORD_W;

  logic [VEC_W-1:0]   wideA;
  logic [VEC_W-1:0]   wideB;
  logic [VEC_W-1:0]   srcA;
  logic [VEC_W-1:0]   srcB;
  logic [VEC_W-1:0]   rawSum;
  logic [VEC_W-1:0]   narrowSum;
  logic [VEC_W-1:0]   nextRes;
  logic [NUM_SEG-1:0] carryIn;
  logic [NUM_SEG-1:0] segBreak;

  // Widening prep: sign-extend the low halfword elements to words.
  for (genvar k = 0; k < NUM_WRD; k++) begin : g_widen
    assign wideA[k*WORD_W +: WORD_W] =
      {{HALF_W{opA[k*HALF_W + HALF_W - 1]}}, opA[k*HALF_W +: HALF_W]};
    assign wideB[k*WORD_W +: WORD_W] =
      {{HALF_W{opB[k*HALF_W + HALF_W - 1]}}, opB[k*HALF_W +: HALF_W]};
  end

  assign srcA = strobes.widen ? wideA : opA;
  assign srcB = strobes.widen ? wideB : opB;

  // Segment 0 never takes a carry; the others take one unless cut.
  assign segBreak   = {strobes.cut, 1'b1};
  assign carryIn[0] = 1'b0;

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    logic segCin;
    assign segCin = carryIn[i] & ~segBreak[i];
    if (i < NUM_SEG - 1) begin : g_mid
      logic [SEG_W:0] segSum;
      assign segSum = {1'b0, srcA[i*SEG_W +: SEG_W]}
                    + {1'b0, srcB[i*SEG_W +: SEG_W]}
                    + {{SEG_W{1'b0}}, segCin};
      assign rawSum[i*SEG_W +: SEG_W] = segSum[SEG_W-1:0];
      assign carryIn[i+1]             = segSum[SEG_W];
    end else begin : g_top
      assign rawSum[i*SEG_W +: SEG_W] = srcA[i*SEG_W +: SEG_W]
                                      + srcB[i*SEG_W +: SEG_W]
                                      + {{(SEG_W-1){1'b0}}, segCin};
    end
  end

  // Narrowing: keep the low half of each word sum, pack it from bit 0 up.
  for (genvar k = 0; k < NUM_WRD; k++) begin : g_narrow
    assign narrowSum[k*HALF_W +: HALF_W] = rawSum[k*WORD_W +: HALF_W];
  end
  assign narrowSum[VEC_W-1:NUM_WRD*HALF_W] = '0;

  always_comb begin
    if (strobes.blank)       nextRes = '0;
    else if (strobes.narrow) nextRes = narrowSum;
    else                     nextRes = rawSum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resValid <= 1'b0;
      resData  <= '0;
    end else begin
      resValid <= strobes.load;
      if (strobes.load) resData <= nextRes;
    end
  end

endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
  import simd_add_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [MODE_W-1:0] inMode,
  input  logic [VEC_W-1:0]  inOpA,
  input  logic [VEC_W-1:0]  inOpB,
  output logic              outValid,
  output logic [VEC_W-1:0]  outResult
);

  ctrlStrobes_t strobes;

  simd_add_ctrl ctrl_i (
    .inValid (inValid),
    .inMode  (inMode),
    .strobes (strobes)
  );

  simd_add_datapath dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .opA      (inOpA),
    .opB      (inOpB),
    .resValid (outValid),
    .resData  (outResult)
  );

endmodule

// File: rtl/simd_add_checker.sv
module simd_add_checker
  import simd_add_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [MODE_W-1:0] inMode,
  input logic [VEC_W-1:0]  inOpA,
  input logic [VEC_W-1:0]  inOpB,
  input logic              outValid,
  input logic [VEC_W-1:0]  outResult
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!outValid && outResult == '0));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && $stable(outResult)));

  assert_byte_lane0_R4: assert property (@(posedge clk) disable iff (rst)
    (inValid && inMode == MODE_B8) |=>
      outResult[7:0] == $past(inOpA[7:0] + inOpB[7:0]));

  assert_narrow_upper_R9: assert property (@(posedge clk) disable iff (rst)
    (inValid && inMode == MODE_NARROW) |=> outResult[VEC_W-1:64] == '0);

  assert_widen_lane0_R10: assert property (@(posedge clk) disable iff (rst)
    (inValid && inMode == MODE_WIDEN) |=>
      outResult[31:0] == $past({{16{inOpA[15]}}, inOpA[15:0]}
                             + {{16{inOpB[15]}}, inOpB[15:0]}));

  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (inValid && inMode[2:1] == 2'b11) |=> outResult == '0);

endmodule

bind simd_lane_adder simd_add_checker chk_i (
  .clk       (clk),
  .rst       (rst),
  .inValid   (inValid),
  .inMode    (inMode),
  .inOpA     (inOpA),
  .inOpB     (inOpB),
  .outValid  (outValid),
  .outResult (outResult)
);

// File: tb/simd_lane_adder_tb.sv
module simd_lane_adder_tb_top;

  logic         clk = 1'b0;
  logic         rst;
  logic         inValid;
  logic [2:0]   inMode;
  logic [127:0] inOpA;
  logic [127:0] inOpB;
  logic         outValid;
  logic [127:0] outResult;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  simd_lane_adder dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inMode(inMode),
    .inOpA(inOpA), .inOpB(inOpB), .outValid(outValid), .outResult(outResult)
  );

  function automatic logic [127:0] refSum(input logic [2:0] m,
                                          input logic [127:0] a,
                                          input logic [127:0] b);
    logic [127:0] r = '0;
    case (m)
      3'd0: for (int i = 0; i < 16; i++) r[i*8 +: 8]   = a[i*8 +: 8] + b[i*8 +: 8];
      3'd1: for (int i = 0; i < 8; i++)  r[i*16 +: 16] = a[i*16 +: 16] + b[i*16 +: 16];
      3'd2: for (int i = 0; i < 4; i++)  r[i*32 +: 32] = a[i*32 +: 32] + b[i*32 +: 32];
      3'd3: for (int i = 0; i < 2; i++)  r[i*64 +: 64] = a[i*64 +: 64] + b[i*64 +: 64];
      3'd4: for (int i = 0; i < 4; i++) begin
              logic [31:0] s = a[i*32 +: 32] + b[i*32 +: 32];
              r[i*16 +: 16] = s[15:0];
            end
      3'd5: for (int i = 0; i < 4; i++)
              r[i*32 +: 32] = {{16{a[i*16+15]}}, a[i*16 +: 16]}
                            + {{16{b[i*16+15]}}, b[i*16 +: 16]};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic check(input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [2:0] m,
                       input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    inValid = 1'b1; inMode = m; inOpA = a; inOpB = b;
    @(negedge clk);
    inValid = 1'b0;
    check({req, " R2 valid"}, {127'd0, outValid}, 128'd1);
    check(req, outResult, refSum(m, a, b));
  endtask

  initial begin
    logic [127:0] ones = '1;
    logic [127:0] held;
    void'($urandom(32'd1234));
    rst = 1'b1; inValid = 1'b0; inMode = '0; inOpA = '0; inOpB = '0;
    repeat (2) @(negedge clk);
    check("R1 reset result", outResult, '0);
    check("R1 reset valid", {127'd0, outValid}, '0);
    rst = 1'b0;

    // Carry must stop at every lane cut: all-ones plus one per lane.
    apply("R4 byte carry cut", 3'd0, ones, {16{8'h01}});
    apply("R5 half carry cut", 3'd1, ones, {8{16'h0001}});
    apply("R6 word carry cut", 3'd2, ones, {4{32'h1}});
    apply("R7 dword carry cut", 3'd3, ones, {2{64'h1}});
    apply("R7 carry into bit 8", 3'd3, {2{64'h00000000_000000ff}}, {2{64'h1}});
    // Lane placement: only element 5 nonzero in halfword mode.
    apply("R8 lane order", 3'd1, 128'h1234 << 80, 128'h0001 << 80);
    apply("R9 narrow overflow", 3'd4,
          {4{32'h0001_ffff}}, {4{32'h0002_0003}});
    apply("R10 widen negative", 3'd5,
          {64'hdead_beef_0000_0000, 16'h8000, 16'hffff, 16'h7fff, 16'hfffe},
          {64'h1234_5678_0000_0000, 16'h8000, 16'h0001, 16'h0001, 16'hfffe});
    apply("R11 reserved 6", 3'd6, rnd128(), rnd128());
    apply("R11 reserved 7", 3'd7, rnd128(), rnd128());

    // Idle cycle with changed inputs must leave the result alone.
    apply("R6 before hold", 3'd2, rnd128(), rnd128());
    held = outResult;
    inMode = 3'd0; inOpA = rnd128(); inOpB = rnd128();
    @(negedge clk);
    check("R3 hold result", outResult, held);
    check("R3 valid low", {127'd0, outValid}, '0);

    for (int n = 0; n < 300; n++) begin
      logic [2:0] m = 3'($urandom_range(0, 7));
      case (m)
        3'd0: apply("R4 random", m, rnd128(), rnd128());
        3'd1: apply("R5 random", m, rnd128(), rnd128());
        3'd2: apply("R6 random", m, rnd128(), rnd128());
        3'd3: apply("R7 random", m, rnd128(), rnd128());
        3'd4: apply("R9 random", m, rnd128(), rnd128());
        3'd5: apply("R10 random", m, rnd128(), rnd128());
        default: apply("R11 random", m, rnd128(), rnd128());
      endcase
    end

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 second reset", outResult, '0);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule